// File: doc/BRIEF.md
# Inter-Core Request/Response Mailbox

This block connects two processors through a small bank of registers. The requesting processor posts a command code and an operand word. The serving processor takes them, does the work outside this block, and then posts a response code and one result word. Each processor has its own register port with a write strobe, a two-bit register address, write data, and read data that follows the address in the same cycle. Both ports see the same four registers.

Two valid flags carry out a four-phase handshake. First, the requester posts a request, which sets request-valid. Second, the server posts a response, which sets response-valid. Third, the requester consumes the result and clears response-valid. Fourth, the server sees that and clears request-valid, which leaves the mailbox idle. Each flag drives an alert to the side that must act on it. A side can set only its own flag and can clear only the other side's flag. When a set and a clear of the same flag happen in the same cycle, the set wins.

Register map, the same on both ports: 0 holds the request command, 1 the request operand, 2 the response code and 3 the response data. In both control registers (0 and 2), bits 4:0 hold the code and bit 5 is the valid flag. In register 0 only, bit 6 is a sticky busy-error flag. All other control bits read as 0.

Top module: `mbx_mailbox`

## Requirements
- R1: Reset clears both valid flags, the error flag, both alerts and all four registers, so every register reads 0.
- R2: When the requester writes register 0 with bit 5 set while request-valid is clear, bits 4:0 are stored as the command code, request-valid is set, and `sv_alert` is high from the next cycle. A requester write to register 0 with bit 5 clear stores nothing.
- R3: A requester write to register 1 stores the operand only while request-valid is clear. The write is ignored while request-valid is set.
- R4: When the requester writes register 0 with bit 5 set while request-valid is already set, the command code is kept and error bit 6 is set. The error bit stays set until the requester writes register 0 with bit 6 set.
- R5: When the server writes register 2, bits 4:0 are stored as the response code. If bit 5 is also set, response-valid is set in the same cycle (for example, 0x22 posts code 0x02 with valid), and `rq_alert` is high from the next cycle.
- R6: A server write to register 3 stores the result word, which the requester can then read at address 3.
- R7: A requester write to register 2 with bit 5 clear clears response-valid and `rq_alert`. The response code is kept.
- R8: A server write to register 0 with bit 5 clear clears request-valid and `sv_alert`. The command code and the error bit are kept.
- R9: If one side clears a flag (request-valid, response-valid or the error bit) in the same cycle that the other side sets it, the flag ends up set.
- R10: A side cannot write the other side's data. The following writes change nothing:
  - requester writes to register 3;
  - requester writes to register 2 with bit 5 set;
  - server writes to register 1;
  - server writes to register 0 with bit 5 set.
- R11: Both read ports return the same contents for the same address with no clock delay. A control register reads as code in bits 4:0, valid in bit 5, and error in bit 6 (register 0 only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_we | input | 1 | Requester write strobe |
| rq_addr | input | 2 | Requester register address |
| rq_wdata | input | 16 | Requester write data |
| rq_rdata | output | 16 | Requester read data |
| rq_alert | output | 1 | Response pending, to requester |
| sv_we | input | 1 | Server write strobe |
| sv_addr | input | 2 | Server register address |
| sv_wdata | input | 16 | Server write data |
| sv_rdata | output | 16 | Server read data |
| sv_alert | output | 1 | Request pending, to server |

## Verification
Two clashes can fall in the same cycle:
- The requester posting a new request while the server releases the old one.
- The server posting a response while the requester acknowledges the previous one.

The bench provokes both by driving the two write ports on the same clock edge. It judges the result by reading the control register back and sampling the alert: both must show the flag set. A third clash is a busy repost that also asks to clear the error bit. The bench checks that the error bit stays set in that case.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned AW      = 2;
  localparam int unsigned VLD_BIT = 5;
  localparam int unsigned ERR_BIT = 6;

  typedef enum logic [AW-1:0] {
    REG_REQ_CMD  = 2'd0,
    REG_REQ_ARG  = 2'd1,
    REG_RSP_CODE = 2'd2,
    REG_RSP_DATA = 2'd3
  } mbx_reg_e;

  function automatic logic reg_hit(input logic we, input logic [AW-1:0] a,
                                   input mbx_reg_e r);
    return we && (a == AW'(r));
  endfunction
endpackage

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);  // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);  // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(q));  // R9
endmodule

// File: rtl/mbx_field.sv
module mbx_field #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_FIELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));  // R10
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] req_code,
  input  logic          req_vld,
  input  logic          req_err,
  input  logic [DW-1:0] req_arg,
  input  logic [CW-1:0] rsp_code,
  input  logic          rsp_vld,
  input  logic [DW-1:0] rsp_data,
  output logic [DW-1:0] rdata
);
  function automatic logic [DW-1:0] ctrl_word(input logic [CW-1:0] code,
                                              input logic vld, input logic err);
    logic [DW-1:0] w;
    w = '0;
    w[CW-1:0]  = code;
    w[VLD_BIT] = vld;
    w[ERR_BIT] = err;
    return w;
  endfunction

  always_comb begin
    unique case (addr)
      AW'(REG_REQ_CMD):  rdata = ctrl_word(req_code, req_vld, req_err);
      AW'(REG_REQ_ARG):  rdata = req_arg;
      AW'(REG_RSP_CODE): rdata = ctrl_word(rsp_code, rsp_vld, 1'b0);
      default:           rdata = rsp_data;
    endcase
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq_we,
  input  logic [1:0]    rq_addr,
  input  logic [DW-1:0] rq_wdata,
  output logic [DW-1:0] rq_rdata,
  output logic          rq_alert,
  input  logic          sv_we,
  input  logic [1:0]    sv_addr,
  input  logic [DW-1:0] sv_wdata,
  output logic [DW-1:0] sv_rdata,
  output logic          sv_alert
);
  localparam int unsigned NPORT = 2;

  // stored state
  logic          req_vld, req_err, rsp_vld;
  logic [CW-1:0] req_code, rsp_code;
  logic [DW-1:0] req_arg, rsp_data;

  // named write events
  logic rq_cmd_wr, rq_post, req_accept, req_reject, err_clear, req_release;
  logic arg_load, rsp_code_wr, rsp_post, rsp_ack, rsp_data_load;

  assign rq_cmd_wr     = reg_hit(rq_we, rq_addr, REG_REQ_CMD);
  assign rq_post       = rq_cmd_wr && rq_wdata[VLD_BIT];
  assign req_accept    = rq_post && !req_vld;
  assign req_reject    = rq_post && req_vld;
  assign err_clear     = rq_cmd_wr && rq_wdata[ERR_BIT];
  assign req_release   = reg_hit(sv_we, sv_addr, REG_REQ_CMD) && !sv_wdata[VLD_BIT];
  assign arg_load      = reg_hit(rq_we, rq_addr, REG_REQ_ARG) && !req_vld;
  assign rsp_code_wr   = reg_hit(sv_we, sv_addr, REG_RSP_CODE);
  assign rsp_post      = rsp_code_wr && sv_wdata[VLD_BIT];
  assign rsp_ack       = reg_hit(rq_we, rq_addr, REG_RSP_CODE) && !rq_wdata[VLD_BIT];
  assign rsp_data_load = reg_hit(sv_we, sv_addr, REG_RSP_DATA);

  mbx_flag u_req_vld (.clk, .rst_n, .set(req_accept), .clr(req_release), .q(req_vld));
  mbx_flag u_req_err (.clk, .rst_n, .set(req_reject), .clr(err_clear),   .q(req_err));
  mbx_flag u_rsp_vld (.clk, .rst_n, .set(rsp_post),   .clr(rsp_ack),     .q(rsp_vld));

  mbx_field #(.W(CW)) u_req_code (.clk, .rst_n, .load(req_accept),
                                  .d(rq_wdata[CW-1:0]), .q(req_code));
  mbx_field #(.W(DW)) u_req_arg  (.clk, .rst_n, .load(arg_load),
                                  .d(rq_wdata), .q(req_arg));
  mbx_field #(.W(CW)) u_rsp_code (.clk, .rst_n, .load(rsp_code_wr),
                                  .d(sv_wdata[CW-1:0]), .q(rsp_code));
  mbx_field #(.W(DW)) u_rsp_data (.clk, .rst_n, .load(rsp_data_load),
                                  .d(sv_wdata), .q(rsp_data));

  // one read mux per port
  logic [AW-1:0] rd_addr [NPORT];
  logic [DW-1:0] rd_data [NPORT];
  assign rd_addr[0] = rq_addr;
  assign rd_addr[1] = sv_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    mbx_rd_mux #(.DW(DW), .CW(CW)) u_mux (
      .addr(rd_addr[p]), .req_code, .req_vld, .req_err, .req_arg,
      .rsp_code, .rsp_vld, .rsp_data, .rdata(rd_data[p]));
  end

  assign rq_rdata = rd_data[0];
  assign sv_rdata = rd_data[1];
  assign rq_alert = rsp_vld;
  assign sv_alert = req_vld;

  AST_REQ_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sv_alert) |-> $past(rq_we && rq_addr == 2'd0 && rq_wdata[VLD_BIT]));  // R2
  AST_RSP_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_alert) |-> $past(sv_we && sv_addr == 2'd2 && sv_wdata[VLD_BIT]));  // R5
  AST_BUSY_POST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_alert && rq_we && rq_addr == 2'd0 && rq_wdata[VLD_BIT]) |=> req_err);  // R4
  AST_BUSY_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_alert && rq_we && rq_addr == 2'd0) |=> $stable(req_code));  // R4
  AST_ARG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sv_alert |=> $stable(req_arg));  // R3
  AST_RSP_DATA_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(sv_we && sv_addr == 2'd3) |=> $stable(rsp_data));  // R10
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_addr == sv_addr) |-> (rq_rdata == sv_rdata));  // R11
endmodule

// File: tb/tb_mbx_mailbox.sv
module tb_mbx_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_we = 1'b0, sv_we = 1'b0;
  logic [1:0]  rq_addr = '0, sv_addr = '0;
  logic [15:0] rq_wdata = '0, sv_wdata = '0;
  logic [15:0] rq_rdata, sv_rdata;
  logic        rq_alert, sv_alert;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mbx_mailbox dut (.clk, .rst_n, .rq_we, .rq_addr, .rq_wdata, .rq_rdata, .rq_alert,
                   .sv_we, .sv_addr, .sv_wdata, .sv_rdata, .sv_alert);

  typedef struct packed {
    logic [3:0]  req;
    logic        rwe;
    logic [1:0]  ra;
    logic [15:0] rd;
    logic        swe;
    logic [1:0]  sa;
    logic [15:0] sd;
    logic [1:0]  ca;
    logic [15:0] exp;
    logic        exp_rq;
    logic        exp_sv;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b1,2'd1,16'h1234, 1'b0,2'd0,16'h0000, 2'd1,16'h1234, 1'b0,1'b0}, // R3 idle store
    '{4'd2,  1'b1,2'd0,16'h0022, 1'b0,2'd0,16'h0000, 2'd0,16'h0022, 1'b0,1'b1}, // R2 post
    '{4'd3,  1'b1,2'd1,16'h5555, 1'b0,2'd0,16'h0000, 2'd1,16'h1234, 1'b0,1'b1}, // R3 locked
    '{4'd4,  1'b1,2'd0,16'h0023, 1'b0,2'd0,16'h0000, 2'd0,16'h0062, 1'b0,1'b1}, // R4 busy repost
    '{4'd10, 1'b0,2'd0,16'h0000, 1'b1,2'd1,16'hBEEF, 2'd1,16'h1234, 1'b0,1'b1}, // R10 server arg
    '{4'd6,  1'b0,2'd0,16'h0000, 1'b1,2'd3,16'hA5C3, 2'd3,16'hA5C3, 1'b0,1'b1}, // R6 result
    '{4'd10, 1'b1,2'd3,16'h0000, 1'b0,2'd0,16'h0000, 2'd3,16'hA5C3, 1'b0,1'b1}, // R10 rq data
    '{4'd10, 1'b1,2'd2,16'h003F, 1'b0,2'd0,16'h0000, 2'd2,16'h0000, 1'b0,1'b1}, // R10 rq rsp set
    '{4'd5,  1'b0,2'd0,16'h0000, 1'b1,2'd2,16'h0022, 2'd2,16'h0022, 1'b1,1'b1}, // R5 respond
    '{4'd7,  1'b1,2'd2,16'h0000, 1'b0,2'd0,16'h0000, 2'd2,16'h0002, 1'b0,1'b1}, // R7 ack
    '{4'd10, 1'b0,2'd0,16'h0000, 1'b1,2'd0,16'h0021, 2'd0,16'h0062, 1'b0,1'b1}, // R10 sv req set
    '{4'd8,  1'b0,2'd0,16'h0000, 1'b1,2'd0,16'h0000, 2'd0,16'h0042, 1'b0,1'b0}, // R8 release
    '{4'd4,  1'b1,2'd0,16'h0040, 1'b0,2'd0,16'h0000, 2'd0,16'h0002, 1'b0,1'b0}, // R4 err clear
    '{4'd9,  1'b1,2'd0,16'h0025, 1'b1,2'd0,16'h0000, 2'd0,16'h0025, 1'b0,1'b1}, // R9 req set wins
    '{4'd9,  1'b1,2'd0,16'h0063, 1'b0,2'd0,16'h0000, 2'd0,16'h0065, 1'b0,1'b1}, // R9 err set wins
    '{4'd4,  1'b1,2'd0,16'h0040, 1'b0,2'd0,16'h0000, 2'd0,16'h0025, 1'b0,1'b1}, // R4 err clear busy
    '{4'd9,  1'b1,2'd2,16'h0000, 1'b1,2'd2,16'h0027, 2'd2,16'h0027, 1'b1,1'b1}, // R9 rsp set wins
    '{4'd7,  1'b1,2'd2,16'h0000, 1'b0,2'd0,16'h0000, 2'd2,16'h0007, 1'b0,1'b1}, // R7 ack again
    '{4'd8,  1'b0,2'd0,16'h0000, 1'b1,2'd0,16'h0000, 2'd0,16'h0005, 1'b0,1'b0}, // R8 release again
    '{4'd3,  1'b1,2'd1,16'h0F0F, 1'b0,2'd0,16'h0000, 2'd1,16'h0F0F, 1'b0,1'b0}  // R3 idle again
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R11: both ports read the same address, no clock edge in between
  task automatic read_both(input string tag, input logic [1:0] a, input logic [15:0] exp);
    rq_addr = a;
    sv_addr = a;
    #1;
    check({tag, " rq port"}, rq_rdata, exp);
    check({tag, " sv port"}, sv_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) read_both("R1 reset", 2'(a), 16'h0000);
    check("R1 reset rq_alert", {15'd0, rq_alert}, 16'd0);
    check("R1 reset sv_alert", {15'd0, sv_alert}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rq_we = VECS[i].rwe; rq_addr = VECS[i].ra; rq_wdata = VECS[i].rd;
      sv_we = VECS[i].swe; sv_addr = VECS[i].sa; sv_wdata = VECS[i].sd;
      @(negedge clk);
      rq_we = 1'b0;
      sv_we = 1'b0;
      read_both($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].ca, VECS[i].exp);
      check($sformatf("R%0d vec %0d rq_alert", VECS[i].req, i), {15'd0, rq_alert},
            {15'd0, VECS[i].exp_rq});
      check($sformatf("R%0d vec %0d sv_alert", VECS[i].req, i), {15'd0, sv_alert},
            {15'd0, VECS[i].exp_sv});
    end

    // R11: combinational read, switch address between edges
    read_both("R11 opnd", 2'd1, 16'h0F0F);
    read_both("R11 data", 2'd3, 16'hA5C3);

    // R1: reset in the middle of an open handshake clears everything
    @(negedge clk);
    rq_we = 1'b1; rq_addr = 2'd0; rq_wdata = 16'h0031;
    sv_we = 1'b1; sv_addr = 2'd2; sv_wdata = 16'h0029;
    @(negedge clk);
    rq_we = 1'b0; sv_we = 1'b0;
    check("R2 pre-reset sv_alert", {15'd0, sv_alert}, 16'd1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) read_both("R1 mid reset", 2'(a), 16'h0000);
    check("R1 mid reset rq_alert", {15'd0, rq_alert}, 16'd0);
    check("R1 mid reset sv_alert", {15'd0, sv_alert}, 16'd0);

    finish_run();
  end
endmodule